// File: doc/BRIEF.md
# Loopback packet generator and checker

This block is the traffic end of a loopback test on a 25G Ethernet MAC. A single start pulse starts one test. The block sends one packet of a programmed byte length on a 64-bit AXI4-Stream transmit port. The payload is an incrementing 16-bit pattern that begins at zero for every test.

The packet then comes back on a 64-bit AXI4-Stream receive port. The block counts the received bytes and rebuilds the expected word for each beat from that running count. It compares the enabled bytes of each beat against the expected word. Once the real payload is used up, the expected bytes become zero, so a short frame that the MAC padded to minimum size passes. A busy flag covers the whole test. The block also latches the MAC error indication that arrives on the last beat.

Three free-running statistics counters sit beside the checker. They count RS-FEC code blocks from a 3-bit per-block status input: all blocks, blocks with correctable errors and blocks with uncorrectable errors. A clear input zeroes all three.

Top module: `lpg_top`

## Requirements
- R1: After reset `busy` is 0. A `start` sampled high while `busy` is 0 makes `busy` 1 at that clock edge. A `start` sampled while `busy` is 1 is ignored and launches no second packet.
- R2: One test sends exactly ceil(len/8) beats. `tx_tvalid` stays high from the first beat until the beat carrying `tx_tlast` is accepted, and is 0 afterwards. `tx_tlast` is 1 on the final beat only.
- R3: Beat n (counted from 0 in each test) carries four 16-bit lanes with the values 4n, 4n+1, 4n+2 and 4n+3. Lane 0 sits in bits 15:0 and lane 3 in bits 63:48. The beat index advances only on a cycle where `tx_tvalid` and `tx_tready` are both 1.
- R4: While `tx_tvalid` is 1 and `tx_tready` is 0, `tx_tdata`, `tx_tkeep` and `tx_tlast` do not change.
- R5: `tx_tkeep` is 8'hFF on every beat except the last. On the last beat, let k = len mod 8. If k is 0, `tx_tkeep` is 8'hFF. Otherwise only the low k bits of `tx_tkeep` are 1.
- R6: For each beat the block takes while busy, `rx_len` grows by 8, or by the number of 1 bits in `rx_tkeep` when `rx_tlast` is 1. The same edge that accepts `start` clears `rx_len` to 0.
- R7: The expected data is compared only on bytes whose `rx_tkeep` bit is 1. A received byte at offset b in the packet is expected to be zero when b >= len; below that it is expected to hold the R3 pattern. Any mismatch sets `verify_fail`. The flag stays set until the next accepted `start`, which clears it.
- R8: `mac_error` takes the value of `rx_tuser` on the beat with `rx_tlast` = 1. `rx_tuser` on other beats has no effect. Accepting `start` clears `mac_error`.
- R9: Let the last receive beat be sampled at clock edge E. Then `busy` is still 1 after E and falls at edge E+1. By that edge `rx_len`, `verify_fail` and `mac_error` hold their final values.
- R10: On each clock edge, `fec_total` (36 bits) adds 1 when `fec_status[0]` is 1. `fec_corr` adds 1 when `fec_status[0]` and `fec_status[1]` are both 1. `fec_uncorr` adds 1 when `fec_status[0]` and `fec_status[2]` are both 1.
- R11: `fec_clear` sampled high sets all three FEC counters to 0. This holds even when `fec_status` would count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts one test when idle |
| len_bytes | input | 14 | Packet length in bytes, valid 1 to 9014 |
| busy | output | 1 | High from start until the returned packet ends |
| tx_tvalid | output | 1 | Transmit beat valid |
| tx_tready | input | 1 | Transmit beat accepted by the sink |
| tx_tdata | output | 64 | Transmit data |
| tx_tkeep | output | 8 | Transmit byte enables |
| tx_tlast | output | 1 | Final transmit beat |
| rx_tvalid | input | 1 | Receive beat valid |
| rx_tdata | input | 64 | Receive data |
| rx_tkeep | input | 8 | Receive byte enables |
| rx_tlast | input | 1 | Final receive beat |
| rx_tuser | input | 1 | MAC error indication, meaningful on the final beat |
| rx_len | output | 16 | Bytes received in the current test |
| verify_fail | output | 1 | Sticky data mismatch flag |
| mac_error | output | 1 | Error indication latched from the final receive beat |
| fec_status | input | 3 | Per-block status: bit 0 block seen, bit 1 correctable, bit 2 uncorrectable |
| fec_clear | input | 1 | Clears all FEC counters |
| fec_total | output | 36 | Count of received FEC blocks |
| fec_corr | output | 32 | Count of blocks with correctable errors |
| fec_uncorr | output | 32 | Count of blocks with uncorrectable errors |

## Verification
Two things can land on the same clock edge.

The first is a FEC counter clear arriving in a cycle where the status input also marks a block with both error bits set. The bench forces that cycle on purpose, with random status before and after it. It expects all three counters to read zero on the following cycle, while its own model keeps adding up the other cycles.

The second is a start pulse arriving while a transmit beat is being accepted mid-packet. The bench expects the start to be ignored. It judges this by the beat count and pattern of the running packet and by transmit valid staying low once the packet ends.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int LEN_W     = 14;
    localparam int BEAT_W    = LEN_W - 2;
    localparam int DATA_W    = 64;
    localparam int KEEP_W    = DATA_W / 8;
    localparam int LANE_W    = 16;
    localparam int LANES     = DATA_W / LANE_W;
    localparam int RXLEN_W   = 16;
    localparam int FEC_TOT_W = 36;
    localparam int FEC_ERR_W = 32;
    localparam int MIN_FRAME = 60;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic [DATA_W-1:0] exp;
    } chk_stage_t;

    // number of 8-byte beats for a byte length (rounded up)
    function automatic logic [BEAT_W-1:0] beat_count(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] t;
        t = {1'b0, len} + (LEN_W+1)'(7);
        return t[LEN_W:3];
    endfunction

    // byte enables of a final beat holding k valid bytes (k==0 means full)
    function automatic logic [KEEP_W-1:0] last_keep(input logic [2:0] k);
        logic [KEEP_W-1:0] m;
        m = '0;
        for (int j = 0; j < KEEP_W; j++)
            if (k == 3'd0 || j < int'(k)) m[j] = 1'b1;
        return m;
    endfunction

    function automatic logic [3:0] ones8(input logic [KEEP_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int j = 0; j < KEEP_W; j++) n = n + {3'b000, v[j]};
        return n;
    endfunction

    // four incrementing lanes starting at base, lane 0 lowest
    function automatic logic [DATA_W-1:0] lane_word(input logic [LANE_W-1:0] base);
        logic [DATA_W-1:0] w;
        for (int i = 0; i < LANES; i++) w[i*LANE_W +: LANE_W] = base + LANE_W'(i);
        return w;
    endfunction

    // keep bytes below the remaining payload count, zero the rest
    function automatic logic [DATA_W-1:0] pad_mask(input logic [LEN_W-1:0] rem);
        logic [DATA_W-1:0] w;
        for (int j = 0; j < KEEP_W; j++) w[j*8 +: 8] = (LEN_W'(j) < rem) ? 8'hFF : 8'h00;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input logic [KEEP_W-1:0] keep);
        logic [DATA_W-1:0] w;
        for (int j = 0; j < KEEP_W; j++) w[j*8 +: 8] = {8{keep[j]}};
        return w;
    endfunction

endpackage

// File: rtl/lpg_tx.sv
module lpg_tx
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [LEN_W-1:0]  len,
    output logic              tvalid,
    input  logic              tready,
    output logic [DATA_W-1:0] tdata,
    output logic [KEEP_W-1:0] tkeep,
    output logic              tlast
);

    logic              active_q;
    logic              last_q;
    logic [BEAT_W-1:0] rem_q;
    logic [LANE_W-1:0] base_q;
    logic [2:0]        tail_q;
    logic [BEAT_W-1:0] nbeats;

    assign nbeats = beat_count(len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            last_q   <= 1'b0;
            rem_q    <= '0;
            base_q   <= '0;
            tail_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            rem_q    <= nbeats;
            base_q   <= '0;
            tail_q   <= len[2:0];
            last_q   <= (nbeats == BEAT_W'(1));
        end else if (active_q && tready) begin
            base_q <= base_q + LANE_W'(LANES);
            if (last_q) begin
                active_q <= 1'b0;
                last_q   <= 1'b0;
            end else begin
                rem_q  <= rem_q - BEAT_W'(1);
                last_q <= (rem_q == BEAT_W'(2));
            end
        end
    end

    assign tvalid = active_q;
    assign tlast  = last_q;
    assign tdata  = lane_word(base_q);
    assign tkeep  = last_q ? last_keep(tail_q) : '1;

    // R4: a stalled beat is held unchanged
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast)));

    // R2: valid does not drop inside a packet
    a_r2_valid_run: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !(tready && tlast)) |=> tvalid);

endmodule

// File: rtl/lpg_rx.sv
module lpg_rx
    import lpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               enable,
    input  logic [LEN_W-1:0]   len,
    input  logic               rx_tvalid,
    input  logic [DATA_W-1:0]  rx_tdata,
    input  logic [KEEP_W-1:0]  rx_tkeep,
    input  logic               rx_tlast,
    input  logic               rx_tuser,
    output logic [RXLEN_W-1:0] rx_len,
    output logic               fail,
    output logic               err,
    output logic               done
);

    logic [RXLEN_W-1:0] len_q;
    logic [LEN_W-1:0]   rem_q;
    logic               fail_q;
    logic               err_q;
    logic               done_q;
    chk_stage_t         stg_q;
    logic               beat;
    logic [RXLEN_W-1:0] step;
    logic [LANE_W-1:0]  base;
    logic [DATA_W-1:0]  exp_word;
    logic               mismatch;

    assign beat     = enable && rx_tvalid && !done_q;
    assign step     = rx_tlast ? RXLEN_W'(ones8(rx_tkeep)) : RXLEN_W'(8);
    assign base     = LANE_W'({len_q[RXLEN_W-1:3], 2'b00});
    assign exp_word = lane_word(base) & pad_mask(rem_q);
    assign mismatch = stg_q.vld && (((stg_q.data ^ stg_q.exp) & byte_mask(stg_q.keep)) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            rem_q  <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            stg_q  <= '0;
        end else if (clear) begin
            len_q  <= '0;
            rem_q  <= len;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            stg_q  <= '0;
        end else begin
            done_q    <= beat && rx_tlast;
            stg_q.vld <= beat;
            if (beat) begin
                len_q      <= len_q + step;
                rem_q      <= (rem_q > LEN_W'(8)) ? rem_q - LEN_W'(8) : '0;
                stg_q.data <= rx_tdata;
                stg_q.keep <= rx_tkeep;
                stg_q.exp  <= exp_word;
                if (rx_tlast) err_q <= rx_tuser;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) fail_q <= 1'b0;
        else if (mismatch) fail_q <= 1'b1;
    end

    assign rx_len = len_q;
    assign fail   = fail_q;
    assign err    = err_q;
    assign done   = done_q;

    // R6: byte count moves only on a taken beat or a clear
    a_r6_len_hold: assert property (@(posedge clk) disable iff (rst)
        (!beat && !clear) |=> $stable(rx_len));

    // R7: mismatch flag is sticky until cleared
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail);

    // R8: error flag changes only on a final beat or a clear
    a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
        (!(beat && rx_tlast) && !clear) |=> $stable(err));

endmodule

// File: rtl/lpg_fec_ctr.sv
module lpg_fec_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + W'(1);
    end

    assign cnt = cnt_q;

    // R11: clear wins over a same-cycle increment
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R10: a counter moves by at most one per cycle
    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/lpg_top.sv
module lpg_top
    import lpg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LEN_W-1:0]     len_bytes,
    output logic                 busy,
    output logic                 tx_tvalid,
    input  logic                 tx_tready,
    output logic [DATA_W-1:0]    tx_tdata,
    output logic [KEEP_W-1:0]    tx_tkeep,
    output logic                 tx_tlast,
    input  logic                 rx_tvalid,
    input  logic [DATA_W-1:0]    rx_tdata,
    input  logic [KEEP_W-1:0]    rx_tkeep,
    input  logic                 rx_tlast,
    input  logic                 rx_tuser,
    output logic [RXLEN_W-1:0]   rx_len,
    output logic                 verify_fail,
    output logic                 mac_error,
    input  logic [2:0]           fec_status,
    input  logic                 fec_clear,
    output logic [FEC_TOT_W-1:0] fec_total,
    output logic [FEC_ERR_W-1:0] fec_corr,
    output logic [FEC_ERR_W-1:0] fec_uncorr
);

    logic busy_q;
    logic launch;
    logic rx_done;

    assign launch = start && !busy_q;

    always_ff @(posedge clk) begin
        if (rst)          busy_q <= 1'b0;
        else if (launch)  busy_q <= 1'b1;
        else if (rx_done) busy_q <= 1'b0;
    end

    assign busy = busy_q;

    lpg_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .len    (len_bytes),
        .tvalid (tx_tvalid),
        .tready (tx_tready),
        .tdata  (tx_tdata),
        .tkeep  (tx_tkeep),
        .tlast  (tx_tlast)
    );

    lpg_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .enable    (busy_q),
        .len       (len_bytes),
        .rx_tvalid (rx_tvalid),
        .rx_tdata  (rx_tdata),
        .rx_tkeep  (rx_tkeep),
        .rx_tlast  (rx_tlast),
        .rx_tuser  (rx_tuser),
        .rx_len    (rx_len),
        .fail      (verify_fail),
        .err       (mac_error),
        .done      (rx_done)
    );

    lpg_fec_ctr #(.W(FEC_TOT_W)) u_fec_total (
        .clk (clk), .rst (rst), .clr (fec_clear),
        .inc (fec_status[0]), .cnt (fec_total)
    );

    lpg_fec_ctr #(.W(FEC_ERR_W)) u_fec_corr (
        .clk (clk), .rst (rst), .clr (fec_clear),
        .inc (fec_status[0] && fec_status[1]), .cnt (fec_corr)
    );

    lpg_fec_ctr #(.W(FEC_ERR_W)) u_fec_uncorr (
        .clk (clk), .rst (rst), .clr (fec_clear),
        .inc (fec_status[0] && fec_status[2]), .cnt (fec_uncorr)
    );

    // R1: a start while busy does not end or restart the test
    a_r1_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !rx_done) |=> busy);

    // R9: busy falls right after the receive side reports completion
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !busy);

endmodule

// File: tb/tb_lpg_top.sv
`timescale 1ns/1ps
module tb_lpg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [13:0] len_bytes = '0;
    logic        busy;
    logic        tx_tvalid;
    logic        tx_tready = 1'b0;
    logic [63:0] tx_tdata;
    logic [7:0]  tx_tkeep;
    logic        tx_tlast;
    logic        rx_tvalid = 1'b0;
    logic [63:0] rx_tdata = '0;
    logic [7:0]  rx_tkeep = '0;
    logic        rx_tlast = 1'b0;
    logic        rx_tuser = 1'b0;
    logic [15:0] rx_len;
    logic        verify_fail;
    logic        mac_error;
    logic [2:0]  fec_status = '0;
    logic        fec_clear = 1'b0;
    logic [35:0] fec_total;
    logic [31:0] fec_corr;
    logic [31:0] fec_uncorr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lpg_top dut (
        .clk(clk), .rst(rst), .start(start), .len_bytes(len_bytes), .busy(busy),
        .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
        .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast),
        .rx_tvalid(rx_tvalid), .rx_tdata(rx_tdata), .rx_tkeep(rx_tkeep),
        .rx_tlast(rx_tlast), .rx_tuser(rx_tuser), .rx_len(rx_len),
        .verify_fail(verify_fail), .mac_error(mac_error),
        .fec_status(fec_status), .fec_clear(fec_clear),
        .fec_total(fec_total), .fec_corr(fec_corr), .fec_uncorr(fec_uncorr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat_word(input int n);
        logic [63:0] w;
        for (int i = 0; i < 4; i++) w[i*16 +: 16] = 16'((4*n + i) & 16'hFFFF);
        return w;
    endfunction

    function automatic logic [7:0] keep_of(input int nbytes);
        logic [7:0] k;
        k = '0;
        for (int j = 0; j < 8; j++) if (j < nbytes) k[j] = 1'b1;
        return k;
    endfunction

    // received word: pattern below len, zero padding at or beyond len
    function automatic logic [63:0] rx_word(input int b, input int len);
        logic [63:0] w;
        logic [63:0] p;
        p = pat_word(b);
        for (int j = 0; j < 8; j++) w[j*8 +: 8] = (b*8 + j < len) ? p[j*8 +: 8] : 8'h00;
        return w;
    endfunction

    task automatic run_test(input int len, input int cbeat, input int cbyte,
                            input bit tuser, input bit poke_start);
        int nb;
        int idx;
        int plen;
        int rb;
        int tail;
        int lastn;
        bit pstall;
        bit exp_fail;
        bit rdy;
        logic [63:0] pd;
        logic [7:0] pk;
        logic pl;
        nb = (len + 7) / 8;
        tail = len % 8;
        idx = 0;
        pstall = 0;
        pd = '0; pk = '0; pl = 1'b0;
        @(negedge clk);
        len_bytes = 14'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
        chk(rx_len == 16'd0, "R6 rx_len cleared", 64'(rx_len), 64'd0);
        chk(verify_fail == 1'b0, "R7 fail cleared", 64'(verify_fail), 64'd0);
        chk(mac_error == 1'b0, "R8 error cleared", 64'(mac_error), 64'd0);
        while (1) begin
            if (!tx_tvalid) begin
                chk(0, "R2 tvalid dropped early", 64'(idx), 64'(nb));
                break;
            end
            if (pstall)
                chk(tx_tdata == pd && tx_tkeep == pk && tx_tlast == pl,
                    "R4 held during stall", tx_tdata, pd);
            chk(tx_tdata == pat_word(idx), "R3 tx pattern", tx_tdata, pat_word(idx));
            chk(tx_tkeep == ((idx == nb-1) ? keep_of(tail == 0 ? 8 : tail) : 8'hFF),
                "R5 tx keep", 64'(tx_tkeep), 64'((idx == nb-1) ? keep_of(tail == 0 ? 8 : tail) : 8'hFF));
            chk(tx_tlast == (idx == nb-1), "R2 tx last", 64'(tx_tlast), 64'(idx == nb-1));
            rdy = ($urandom % 4) != 0;
            tx_tready = rdy;
            start = (poke_start && idx == 1) ? 1'b1 : 1'b0;
            pd = tx_tdata; pk = tx_tkeep; pl = tx_tlast;
            pstall = !rdy;
            @(negedge clk);
            if (rdy) begin
                idx++;
                if (idx == nb) break;
            end
        end
        tx_tready = 1'b0;
        start = 1'b0;
        chk(idx == nb, "R2 beat count", 64'(idx), 64'(nb));
        chk(tx_tvalid == 1'b0, "R2 tvalid low after last", 64'(tx_tvalid), 64'd0);
        plen = (len < 60) ? 60 : len;
        rb = (plen + 7) / 8;
        lastn = (plen % 8 == 0) ? 8 : plen % 8;
        exp_fail = (cbeat >= 0 && cbeat < rb && cbyte < ((cbeat == rb-1) ? lastn : 8));
        for (int b = 0; b < rb; b++) begin
            if ($urandom % 3 == 0) begin
                rx_tvalid = 1'b0;
                @(negedge clk);
            end
            rx_tvalid = 1'b1;
            rx_tdata  = rx_word(b, len);
            if (b == cbeat) rx_tdata[cbyte*8] = ~rx_tdata[cbyte*8];
            rx_tkeep  = (b == rb-1) ? keep_of(lastn) : 8'hFF;
            rx_tlast  = (b == rb-1);
            rx_tuser  = (b == rb-1) ? tuser : ~tuser;
            @(negedge clk);
        end
        rx_tvalid = 1'b0;
        rx_tlast  = 1'b0;
        rx_tuser  = 1'b0;
        chk(busy == 1'b1, "R9 busy one cycle after last", 64'(busy), 64'd1);
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy falls", 64'(busy), 64'd0);
        chk(rx_len == 16'(plen), "R6 rx byte count", 64'(rx_len), 64'(plen));
        chk(verify_fail == exp_fail, "R7 verify result", 64'(verify_fail), 64'(exp_fail));
        chk(mac_error == tuser, "R8 error from last tuser", 64'(mac_error), 64'(tuser));
        chk(tx_tvalid == 1'b0, "R1 no relaunch", 64'(tx_tvalid), 64'd0);
    endtask

    task automatic run_fec(input int ncyc);
        logic [35:0] m_tot;
        logic [31:0] m_cor;
        logic [31:0] m_unc;
        logic [2:0] st;
        logic cl;
        bit was_clear;
        m_tot = '0; m_cor = '0; m_unc = '0;
        was_clear = 0;
        @(negedge clk);
        fec_clear = 1'b1;
        fec_status = '0;
        @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            if (was_clear)
                chk(fec_total == 36'd0 && fec_corr == 32'd0 && fec_uncorr == 32'd0,
                    "R11 clear wins", 64'(fec_total), 64'd0);
            chk(fec_total == m_tot && fec_corr == m_cor && fec_uncorr == m_unc,
                "R10 fec counts", {fec_corr, fec_uncorr}, {m_cor, m_unc});
            st = 3'($urandom);
            cl = (k % 97 == 50);
            if (k == 120) begin st = 3'b111; cl = 1'b1; end
            if (k == 121) st = 3'b110;
            fec_status = st;
            fec_clear = cl;
            was_clear = cl;
            if (cl) begin
                m_tot = '0; m_cor = '0; m_unc = '0;
            end else begin
                if (st[0]) m_tot = m_tot + 36'd1;
                if (st[0] && st[1]) m_cor = m_cor + 32'd1;
                if (st[0] && st[2]) m_unc = m_unc + 32'd1;
            end
            @(negedge clk);
        end
        fec_status = '0;
        fec_clear = 1'b0;
        chk(fec_total == m_tot && fec_corr == m_cor && fec_uncorr == m_unc,
            "R10 fec final", 64'(fec_total), 64'(m_tot));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", 64'(busy), 64'd0);
        chk(tx_tvalid == 1'b0, "R2 reset tvalid", 64'(tx_tvalid), 64'd0);
        chk(rx_len == 16'd0 && verify_fail == 1'b0 && mac_error == 1'b0,
            "R6 reset rx state", 64'(rx_len), 64'd0);
        chk(fec_total == 36'd0 && fec_corr == 32'd0 && fec_uncorr == 32'd0,
            "R10 reset fec", 64'(fec_total), 64'd0);
        // directed corner cases
        run_test(1,    -1, 0, 1'b0, 1'b0);
        run_test(8,    -1, 0, 1'b0, 1'b0);
        run_test(9,    -1, 0, 1'b0, 1'b1);
        run_test(59,   -1, 0, 1'b0, 1'b0);
        run_test(60,   -1, 0, 1'b0, 1'b0);
        run_test(61,   -1, 0, 1'b1, 1'b0);
        run_test(1514, -1, 0, 1'b0, 1'b0);
        run_test(9014, -1, 0, 1'b0, 1'b0);
        run_test(13,    7, 6, 1'b0, 1'b0);  // byte with keep clear: ignored
        run_test(20,    3, 0, 1'b0, 1'b0);  // nonzero padding byte: fail
        run_test(100,   5, 3, 1'b1, 1'b0);  // payload mismatch plus error
        run_test(30,   -1, 0, 1'b0, 1'b0);  // flags cleared by new start
        // random lengths
        for (int t = 0; t < 10; t++) begin
            int l;
            int cb;
            l = 1 + int'($urandom % 2000);
            cb = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
            run_test(l, cb, int'($urandom % 8), 1'($urandom), 1'($urandom));
        end
        run_fec(300);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule